// File: doc/BRIEF.md
# SPI Flash Command Shift Engine

This block is a register-programmed, single-lane SPI master that issues short flash commands of arbitrary shape: an opcode, address bytes and payload, followed by any number of response bits. Software fills a six-byte transmit window, writes a transfer length in bits, then sets the start bit of the command register. The engine asserts chip select, generates a mode-0 serial clock from a fixed divider, shifts the window out most significant bit first and captures the incoming line into a ten-byte receive window. When the last bit is done it releases chip select and clears the start bit, which software polls.

The transmit window drains from its highest index downward, so the first command byte belongs in index 5. The receive window is right-aligned: index 0 always holds the most recently received eight bits. Unused transmit positions and bits beyond the window go out as zero, so one mechanism serves write-style commands and read-style commands.

Top module: `spi_gen_engine`

## Requirements
- R1: Writing the command register (offset 0x00) with bit 2 set starts a transfer; bit 2 reads back 1 from the cycle after the start until the transfer ends, and 0 afterwards.
- R2: The bit count register (offset 0x04, bits 7:0) sets the transfer length; values above 56 are treated as 56, and a start with a count of 0 is ignored (no chip select, bit 2 stays 0).
- R3: Transmit byte i (i = 0..5) sits at offset 0x20 + 4*i; index 5 is sent first, then 4 down to 0, each byte MSB first.
- R4: Bits 49 to 56 of a transfer carry 0 on MOSI, and MOSI is 0 whenever chip select is high.
- R5: At the end of every transfer the whole transmit window returns to zero, so positions not reloaded before the next start send zero.
- R6: Receive byte j (j = 0..9) sits at offset 0x40 + 4*j; the window is zeroed at start, and after an N-bit transfer the received stream is right-aligned, its last bit in bit 0 of index 0.
- R7: SPI mode 0: SCK idles low, MISO is sampled on the rising SCK edge and MOSI changes only while SCK is low.
- R8: Chip select falls one SCK half-period before the first rising edge and rises one half-period after the last falling edge.
- R9: A start written while a transfer is in progress is ignored: the running transfer keeps its length and no second frame follows.
- R10: A transfer with effective count N produces exactly N SCK pulses inside one chip-select frame.
- R11: After reset chip select is high, SCK and MOSI are low and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write enable for the access |
| bus_addr_i | input | 8 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_sck_o | output | 1 | Serial clock |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |

## Verification
The hardest state to reach from the ports is a start request that lands in the middle of a frame, after the bit count register has already been rewritten to a different value; the bench issues both writes while the first frame is shifting and then counts clock pulses and frames to show neither took effect. The other corner is the tail of a long transfer where the transmit window has run dry, reached by sweeping every legal length from 1 to 56 with random window contents and a random slave response, plus over-range counts that must clamp.

// File: rtl/spi_gen_pkg.sv
package spi_gen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_HOLD
  } seq_state_e;

  localparam logic [7:0] OFF_CMD = 8'h00;
  localparam logic [7:0] OFF_CNT = 8'h04;
  localparam logic [7:0] OFF_TX  = 8'h20;
  localparam logic [7:0] OFF_RX  = 8'h40;
  localparam int         START_BIT = 2;

endpackage

// File: rtl/spi_gen_regfile.sv
module spi_gen_regfile
  import spi_gen_pkg::*;
#(
  parameter int TX_BYTES = 6,
  parameter int RX_BYTES = 10,
  parameter int AW       = 8,
  parameter int DW       = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [AW-1:0]         addr_i,
  input  logic [DW-1:0]         wdata_i,
  output logic [DW-1:0]         rdata_o,
  input  logic                  busy_i,
  input  logic                  done_i,
  input  logic [RX_BYTES*8-1:0] rx_i,
  output logic                  start_o,
  output logic [7:0]            cnt_o,
  output logic [TX_BYTES*8-1:0] tx_o
);

  localparam logic [AW-1:0] A_CMD = AW'(OFF_CMD);
  localparam logic [AW-1:0] A_CNT = AW'(OFF_CNT);

  logic       wr;
  logic [7:0] cnt_q;
  logic       unused_wdata;

  assign wr           = req_i && we_i;
  assign unused_wdata = ^wdata_i[DW-1:8];

  for (genvar g = 0; g < TX_BYTES; g++) begin : g_tx
    localparam logic [AW-1:0] A_TX = AW'(OFF_TX) + AW'(4 * g);
    logic [7:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      byte_q <= '0;
      else if (done_i)                  byte_q <= '0;  // window self-clears
      else if (wr && addr_i == A_TX)    byte_q <= wdata_i[7:0];
    end
    assign tx_o[g*8 +: 8] = byte_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (wr && addr_i == A_CNT) cnt_q <= wdata_i[7:0];
  end

  assign cnt_o   = cnt_q;
  assign start_o = wr && (addr_i == A_CMD) && wdata_i[START_BIT];

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CMD) rdata_o[START_BIT] = busy_i;
    if (addr_i == A_CNT) rdata_o[7:0] = cnt_q;
    for (int i = 0; i < TX_BYTES; i++)
      if (addr_i == AW'(OFF_TX) + AW'(4 * i)) rdata_o[7:0] = tx_o[i*8 +: 8];
    for (int j = 0; j < RX_BYTES; j++)
      if (addr_i == AW'(OFF_RX) + AW'(4 * j)) rdata_o[7:0] = rx_i[j*8 +: 8];
  end

endmodule

// File: rtl/spi_gen_tick.sv
module spi_gen_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);

  if (HALF_DIV == 1) begin : g_pass
    assign tick_o = run_i;
  end else begin : g_div
    localparam int HW = $clog2(HALF_DIV);
    logic [HW-1:0] cnt_q;
    assign tick_o = run_i && (cnt_q == HW'(HALF_DIV - 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (!run_i) cnt_q <= '0;
      else if (tick_o) cnt_q <= '0;
      else             cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/spi_gen_shifter.sv
module spi_gen_shifter
  import spi_gen_pkg::*;
#(
  parameter int TX_BYTES = 6,
  parameter int RX_BYTES = 10,
  parameter int MAX_BITS = 56
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [7:0]            cnt_i,
  input  logic [TX_BYTES*8-1:0] tx_i,
  input  logic                  tick_i,
  input  logic                  miso_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  cs_n_o,
  output logic                  sck_o,
  output logic                  mosi_o,
  output logic [RX_BYTES*8-1:0] rx_o
);

  localparam int TX_W = TX_BYTES * 8;
  localparam int SH_W = MAX_BITS;        // must be >= TX_W
  localparam int RX_W = RX_BYTES * 8;
  localparam int CW   = $clog2(MAX_BITS + 1);
  localparam int PAD  = SH_W - TX_W;

  seq_state_e      state_q;
  logic [SH_W-1:0] sh_q;
  logic [CW-1:0]   left_q;
  logic [RX_W-1:0] rx_q;
  logic            cs_n_q;
  logic            sck_q;
  logic [CW-1:0]   eff_bits;

  always_comb begin
    if (cnt_i > 8'(MAX_BITS)) eff_bits = CW'(MAX_BITS);
    else                      eff_bits = cnt_i[CW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      left_q  <= '0;
      rx_q    <= '0;
      cs_n_q  <= 1'b1;
      sck_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_i && eff_bits != '0) begin
            state_q <= ST_LOW;
            sh_q    <= SH_W'(tx_i) << PAD;  // top index leads, tail zero
            left_q  <= eff_bits;
            rx_q    <= '0;
            cs_n_q  <= 1'b0;
          end
        end
        ST_LOW: begin
          if (tick_i) begin
            sck_q   <= 1'b1;
            rx_q    <= {rx_q[RX_W-2:0], miso_i};
            state_q <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (tick_i) begin
            sck_q  <= 1'b0;
            left_q <= left_q - 1'b1;
            if (left_q == CW'(1)) begin
              state_q <= ST_HOLD;
            end else begin
              sh_q    <= sh_q << 1;
              state_q <= ST_LOW;
            end
          end
        end
        ST_HOLD: begin
          if (tick_i) begin
            cs_n_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_HOLD) && tick_i;
  assign cs_n_o = cs_n_q;
  assign sck_o  = sck_q;
  assign mosi_o = (state_q == ST_LOW || state_q == ST_HIGH) ? sh_q[SH_W-1] : 1'b0;
  assign rx_o   = rx_q;

endmodule

// File: rtl/spi_gen_engine.sv
module spi_gen_engine #(
  parameter int TX_BYTES = 6,
  parameter int RX_BYTES = 10,
  parameter int MAX_BITS = 56,
  parameter int HALF_DIV = 2,
  parameter int AW       = 8,
  parameter int DW       = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_req_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          spi_cs_no,
  output logic          spi_sck_o,
  output logic          spi_mosi_o,
  input  logic          spi_miso_i
);

  logic                  start;
  logic [7:0]            cnt;
  logic [TX_BYTES*8-1:0] tx;
  logic [RX_BYTES*8-1:0] rx;
  logic                  busy;
  logic                  done;
  logic                  tick;

  spi_gen_regfile #(
    .TX_BYTES(TX_BYTES), .RX_BYTES(RX_BYTES), .AW(AW), .DW(DW)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (bus_req_i),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .busy_i  (busy),
    .done_i  (done),
    .rx_i    (rx),
    .start_o (start),
    .cnt_o   (cnt),
    .tx_o    (tx)
  );

  spi_gen_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .tick_o (tick)
  );

  spi_gen_shifter #(
    .TX_BYTES(TX_BYTES), .RX_BYTES(RX_BYTES), .MAX_BITS(MAX_BITS)
  ) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .cnt_i   (cnt),
    .tx_i    (tx),
    .tick_i  (tick),
    .miso_i  (spi_miso_i),
    .busy_o  (busy),
    .done_o  (done),
    .cs_n_o  (spi_cs_no),
    .sck_o   (spi_sck_o),
    .mosi_o  (spi_mosi_o),
    .rx_o    (rx)
  );

endmodule

// File: rtl/spi_gen_engine_chk.sv
module spi_gen_engine_chk #(
  parameter int MAX_BITS = 56
) (
  input logic clk_i,
  input logic rst_ni,
  input logic spi_cs_no,
  input logic spi_sck_o,
  input logic spi_mosi_o,
  input logic busy_i
);

  logic       sck_d;
  logic [7:0] pulses_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d    <= 1'b0;
      pulses_q <= '0;
    end else begin
      sck_d <= spi_sck_o;
      if (spi_cs_no)                pulses_q <= '0;
      else if (spi_sck_o && !sck_d) pulses_q <= pulses_q + 1'b1;
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o); // R7

  AST_MOSI_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_sck_o && $past(spi_sck_o)) |-> $stable(spi_mosi_o)); // R7

  AST_MOSI_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_mosi_o); // R4

  AST_CS_WITHIN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_cs_no |-> busy_i); // R1

  AST_CS_LEADS_SCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_sck_o) |-> !$past(spi_cs_no)); // R8

  AST_CS_TRAILS_SCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_cs_no) |-> !$past(spi_sck_o)); // R8

  AST_PULSE_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulses_q <= 8'(MAX_BITS)); // R10

endmodule

bind spi_gen_engine spi_gen_engine_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .spi_cs_no  (spi_cs_no),
  .spi_sck_o  (spi_sck_o),
  .spi_mosi_o (spi_mosi_o),
  .busy_i     (busy)
);

// File: tb/sim_spi_gen_engine.sv
module sim_spi_gen_engine;

  localparam int PER  = 4;
  localparam int HALF = 2;
  localparam logic [7:0] A_CMD = 8'h00, A_CNT = 8'h04, A_TX = 8'h20, A_RX = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cs_n, sck, mosi, miso;

  always #(PER/2) clk = ~clk;

  spi_gen_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .spi_cs_no(cs_n), .spi_sck_o(sck), .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  int vecs = 0, errs = 0;

  // slave model and monitor
  int          rises = 0, falls = 0, frames = 0;
  logic [63:0] mos_rec = '0;
  logic [63:0] pat = '0;
  time         t_cs_fall = 0, t_first = 0, t_last_fall = 0, t_cs_rise = 0;
  logic        prev_sck = 1'b0, prev_cs = 1'b1;

  assign miso = (falls < 64) ? pat[63 - falls] : 1'b0;

  always @(sck or cs_n) begin
    if (prev_cs && !cs_n) begin
      rises = 0; falls = 0; mos_rec = '0; t_cs_fall = $time; frames++;
    end
    if (!prev_cs && cs_n) t_cs_rise = $time;
    if (!prev_sck && sck) begin
      if (rises == 0) t_first = $time;
      rises++;
      mos_rec = {mos_rec[62:0], mosi};
    end
    if (prev_sck && !sck) begin
      falls++; t_last_fall = $time;
    end
    prev_sck = sck; prev_cs = cs_n;
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; req = 1'b1; we = 1'b0;
    #1 d = rdata; req = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    do bus_rd(A_CMD, d); while (d[2]);
  endtask

  logic [31:0] seed = 32'h1234_5678;
  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic run_xfer(input int n_prog, input logic [47:0] txw, input logic [63:0] p);
    logic [31:0] d;
    logic [55:0] full;
    logic [63:0] exp_mos;
    logic [79:0] exp_rx;
    logic [7:0]  orv;
    int n;
    pat = p;
    for (int i = 0; i < 6; i++) bus_wr(A_TX + 8'(4 * i), {24'h0, txw[8*i +: 8]});
    bus_wr(A_CNT, 32'(n_prog));
    bus_wr(A_CMD, 32'h4);
    bus_rd(A_CMD, d);
    chk(d[2] == 1'b1, "R1 busy after start", 64'(d[2]), 64'd1);
    wait_idle();
    n = (n_prog > 56) ? 56 : n_prog;
    full = {txw[47:40], txw[39:32], txw[31:24], txw[23:16], txw[15:8], txw[7:0], 8'h00};
    exp_mos = 64'(full >> (56 - n));
    chk(mos_rec == exp_mos, "R3/R4 mosi stream", mos_rec, exp_mos);
    chk(rises == n, "R10 sck pulses", 64'(rises), 64'(n));
    chk(t_first - t_cs_fall == HALF * PER, "R8 cs lead", 64'(t_first - t_cs_fall), 64'(HALF * PER));
    chk(t_cs_rise - t_last_fall == HALF * PER, "R8 cs trail", 64'(t_cs_rise - t_last_fall), 64'(HALF * PER));
    exp_rx = 80'(p >> (64 - n));
    for (int j = 0; j < 10; j++) begin
      bus_rd(A_RX + 8'(4 * j), d);
      chk(d[7:0] == exp_rx[8*j +: 8], "R6 rx byte", 64'(d), 64'(exp_rx[8*j +: 8]));
    end
    orv = '0;
    for (int i = 0; i < 6; i++) begin
      bus_rd(A_TX + 8'(4 * i), d);
      orv = orv | d[7:0];
    end
    chk(orv == 8'h00, "R5 tx window cleared", 64'(orv), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL R10 watchdog expired act=%0d exp=%0d", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [7:0]  orv;
    int f0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(cs_n == 1'b1 && sck == 1'b0 && mosi == 1'b0, "R11 pins",
        64'({cs_n, sck, mosi}), 64'b100);
    orv = '0;
    bus_rd(A_CMD, d); orv = orv | d[7:0];
    bus_rd(A_CNT, d); orv = orv | d[7:0];
    for (int i = 0; i < 6; i++) begin bus_rd(A_TX + 8'(4 * i), d); orv = orv | d[7:0]; end
    for (int j = 0; j < 10; j++) begin bus_rd(A_RX + 8'(4 * j), d); orv = orv | d[7:0]; end
    chk(orv == 8'h00, "R11 regs zero", 64'(orv), 64'd0);

    // full length sweep, R3 R4 R6 R7 R8 R10
    for (int n = 1; n <= 56; n++) run_xfer(n, {rnd(), rnd()}, {rnd(), rnd()});

    // R2 clamping of over-range counts
    run_xfer(60, 48'h0123_4567_89ab, 64'hfedc_ba98_7654_3210);
    run_xfer(255, 48'hffff_ffff_ffff, 64'hffff_ffff_ffff_ffff);

    // R5 only the top byte loaded; the rest must go out as zero
    pat = 64'h0;
    bus_wr(A_TX + 8'd20, 32'hA5);
    bus_wr(A_CNT, 32'd48);
    bus_wr(A_CMD, 32'h4);
    wait_idle();
    chk(mos_rec == 64'h0000_A500_0000_0000, "R5 unloaded bytes zero", mos_rec, 64'h0000_A500_0000_0000);

    // R2 zero count is ignored
    f0 = frames;
    bus_wr(A_CNT, 32'd0);
    bus_wr(A_CMD, 32'h4);
    bus_rd(A_CMD, d);
    chk(d[2] == 1'b0, "R2 zero count no busy", 64'(d[2]), 64'd0);
    repeat (10) @(negedge clk);
    chk(frames == f0 && cs_n == 1'b1, "R2 zero count no frame", 64'(frames - f0), 64'd0);

    // R9 start during a transfer is ignored
    f0 = frames;
    pat = 64'h5555_5555_5555_5555;
    bus_wr(A_CNT, 32'd16);
    bus_wr(A_CMD, 32'h4);
    repeat (6) @(negedge clk);
    bus_wr(A_CNT, 32'd40);
    bus_wr(A_CMD, 32'h4);
    wait_idle();
    chk(rises == 16, "R9 length kept", 64'(rises), 64'd16);
    repeat (20) @(negedge clk);
    chk(frames == f0 + 1, "R9 no second frame", 64'(frames - f0), 64'd1);
    chk(cs_n == 1'b1, "R9 cs released", 64'(cs_n), 64'd1);

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule